// File: doc/BRIEF.md
# Pipelined Burst Static Memory

This block is a synthesizable model of a single-port synchronous static memory with a registered read path. Every control input is sampled on the rising clock edge except the output enable, which gates the read data combinationally. A cycle starts an access when one of two address strobes is low and all three chip enables are active. The processor-side strobe wins over the controller-side strobe. Only the controller-side strobe, or a later burst beat, may write.

After a start, the two low address bits seed a two-bit beat counter. The advance input steps through a four-word group. The group is walked in wrapping linear order or in XOR order, chosen by a static strap. Writes are qualified in two layers: a global write enable covers every byte lane, and otherwise a byte-write enable combines with a select for each lane. Read data is registered. The data bus is modelled as separate write-data, read-data and output-valid signals. A sleep input freezes the memory and deselects it.

Top module: `burst_sram`

## Requirements
- R1: An access starts only when a strobe is low with `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe seen while an enable is inactive deselects the block, and later burst cycles do nothing until the next start.
- R2: When both strobes are low in the same cycle, `ads_proc_n` governs. A start through it is always a read: the write enables and `wdata` are ignored in that cycle. A start through `ads_ctrl_n` writes if the write enables ask for it and reads otherwise.
- R3: `ads_proc_n` has no effect while `ce1_n` is high. That cycle acts as an ordinary burst cycle, or as idle when the block is deselected. `ads_ctrl_n` has no such exemption.
- R4: In a burst cycle, `adv_n`=0 steps the beat count by one and `adv_n`=1 repeats the current word. The count wraps after four beats, and address bits above bit 1 never change within a burst.
- R5: With `order_sel`=0, beat k addresses low bits (s+k) mod 4, where s is the low two bits of the start address. With `order_sel`=1, beat k addresses s XOR k.
- R6: `gw_n`=0 in a writing cycle writes all lanes, whatever `bwe_n` and `bsel_n` are.
- R7: With `gw_n`=1, lane i (bits 8i+7..8i) is written only when `bwe_n`=0 and `bsel_n[i]`=0. Unselected lanes keep their contents.
- R8: The word for a read access sampled at edge N appears on `rdata` after edge N+1.
- R9: `dout_valid` is high only while `oe_n`=0 and the data register holds read data. It stays low in the first clock of a read that starts from the deselected state.
- R10: While `sleep`=1, nothing is read or written and the stored contents are kept. The block leaves sleep deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control and pipeline state |
| addr | input | AW (6) | Word address |
| ads_proc_n | input | 1 | Processor-side address strobe, active low, read start |
| ads_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates `ads_proc_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES (8) | Per-lane byte select, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| order_sel | input | 1 | Static strap: 0 linear, 1 XOR burst order |
| sleep | input | 1 | Sleep request, active high |
| wdata | input | W (64) | Write data |
| rdata | output | W (64) | Registered read data |
| dout_valid | output | 1 | Read data is being driven |

## Verification
The hardest case to reach from the ports is a processor strobe that arrives mid-burst with `ce1_n` high. It must behave as a plain advance, not as a restart or a deselect. The bench reaches it by opening a burst with the controller strobe, then raising `ce1_n` and lowering `ads_proc_n` together with `adv_n` on the next beat. It then checks that the second beat's word comes out. The first-clock output mask needs a deselect cycle immediately before a read start, so every bench operation ends with an enable-inactive strobe. Full memory sweeps in both burst orders, started at every offset, cover the wrap points.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE     = 2'd0,
    CYC_START_RD = 2'd1,
    CYC_START_WR = 2'd2,
    CYC_CONT     = 2'd3
  } cyc_kind_t;

  // Low address bits of a beat inside a four-word group.
  function automatic logic [1:0] beat_offset(input logic [1:0] seed,
                                             input logic [1:0] beat,
                                             input logic       xor_order);
    return xor_order ? (seed ^ beat) : (seed + beat);
  endfunction

  // Lane write qualification: global write beats the byte layer.
  function automatic logic lane_write(input logic gw_n, input logic bwe_n,
                                      input logic sel_n);
    return !gw_n || (!bwe_n && !sel_n);
  endfunction

endpackage

// File: rtl/bsram_ctl.sv
module bsram_ctl
  import bsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ads_proc_n,
  input  logic          ads_ctrl_n,
  input  logic          adv_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          order_sel,
  input  logic          sleep,
  output logic          access,
  output logic          wr_allowed,
  output logic          start,
  output logic          emerge,
  output logic [AW-1:0] acc_addr
);

  cyc_kind_t     kind;
  logic          active_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_n;
  logic          ce_all;
  logic          proc_seen;
  logic          ctrl_seen;

  assign ce_all    = !ce1_n && ce2 && !ce3_n;
  assign proc_seen = !ads_proc_n && !ce1_n;
  assign ctrl_seen = !ads_ctrl_n && !proc_seen;

  always_comb begin
    kind = CYC_IDLE;
    if (!sleep) begin
      if (proc_seen || ctrl_seen) begin
        if (ce_all) kind = proc_seen ? CYC_START_RD : CYC_START_WR;
      end else if (active_q) begin
        kind = CYC_CONT;
      end
    end
  end

  assign start      = (kind == CYC_START_RD) || (kind == CYC_START_WR);
  assign access     = (kind != CYC_IDLE);
  assign wr_allowed = (kind == CYC_START_WR) || (kind == CYC_CONT);
  assign emerge     = start && !active_q;
  assign cnt_n      = (kind == CYC_CONT && !adv_n) ? cnt_q + 2'd1 : cnt_q;

  always_comb begin
    if (start) acc_addr = addr;
    else acc_addr = {base_q[AW-1:2], beat_offset(base_q[1:0], cnt_n, order_sel)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= 2'd0;
    end else begin
      active_q <= access;
      if (start) begin
        base_q <= addr;
        cnt_q  <= 2'd0;
      end else if (kind == CYC_CONT) begin
        cnt_q <= cnt_n;
      end
    end
  end

endmodule

// File: rtl/bsram_lanes.sv
module bsram_lanes
  import bsram_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             access,
  input  logic             wr_allowed,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  output logic [LANES-1:0] lane_we
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = access && wr_allowed && lane_write(gw_n, bwe_n, bsel_n[g]);
  end

endmodule

// File: rtl/bsram_store.sv
module bsram_store #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_we,
  input  logic [AW-1:0]    acc_addr,
  input  logic [W-1:0]     wdata,
  input  logic             rd_req,
  output logic [W-1:0]     rdata,
  output logic             rd_done
);

  logic [AW-1:0] addr_q;
  logic          rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rd_q    <= 1'b0;
      rd_done <= 1'b0;
    end else begin
      rd_q    <= rd_req;
      rd_done <= rd_q;
      if (rd_req) addr_q <= acc_addr;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (rd_q) q <= mem[addr_q];
    end

    assign rdata[g*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             ads_proc_n,
  input  logic             ads_ctrl_n,
  input  logic             adv_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  input  logic             oe_n,
  input  logic             order_sel,
  input  logic             sleep,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic             dout_valid
);

  logic             access;
  logic             wr_allowed;
  logic             start;
  logic             emerge;
  logic [AW-1:0]    acc_addr;
  logic [LANES-1:0] lane_we;
  logic             rd_req;
  logic             rd_done;
  logic             first_q;

  bsram_ctl #(.AW(AW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .adv_n      (adv_n),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .order_sel  (order_sel),
    .sleep      (sleep),
    .access     (access),
    .wr_allowed (wr_allowed),
    .start      (start),
    .emerge     (emerge),
    .acc_addr   (acc_addr)
  );

  bsram_lanes #(.LANES(LANES)) u_lanes (
    .access     (access),
    .wr_allowed (wr_allowed),
    .gw_n       (gw_n),
    .bwe_n      (bwe_n),
    .bsel_n     (bsel_n),
    .lane_we    (lane_we)
  );

  assign rd_req = access && (lane_we == '0);

  bsram_store #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_we  (lane_we),
    .acc_addr (acc_addr),
    .wdata    (wdata),
    .rd_req   (rd_req),
    .rdata    (rdata),
    .rd_done  (rd_done)
  );

  // Marks the first clock of a read that left the deselected state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= 1'b0;
    else first_q <= emerge && rd_req;
  end

  assign dout_valid = !oe_n && rd_done;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ads_proc_n,
  input logic             ads_ctrl_n,
  input logic             ce1_n,
  input logic             gw_n,
  input logic             oe_n,
  input logic             sleep,
  input logic             dout_valid,
  input logic             access,
  input logic             wr_allowed,
  input logic             start,
  input logic             first_q,
  input logic [LANES-1:0] lane_we
);

  a_r10_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we == '0 && !access));

  a_r9_oe_gates_output: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_valid);

  a_r9_first_clock_masked: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |-> !dout_valid);

  a_r2_proc_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_proc_n && !ce1_n) |-> (lane_we == '0));

  a_r3_ce1_blocks_proc: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_ctrl_n && ce1_n) |-> !start);

  a_r6_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (access && wr_allowed && !gw_n) |-> (&lane_we));

endmodule

bind burst_sram bsram_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ads_proc_n (ads_proc_n),
  .ads_ctrl_n (ads_ctrl_n),
  .ce1_n      (ce1_n),
  .gw_n       (gw_n),
  .oe_n       (oe_n),
  .sleep      (sleep),
  .dout_valid (dout_valid),
  .access     (access),
  .wr_allowed (wr_allowed),
  .start      (start),
  .first_q    (first_q),
  .lane_we    (lane_we)
);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic        ads_proc_n, ads_ctrl_n, adv_n, ce1_n, ce2, ce3_n;
  logic        gw_n, bwe_n, oe_n, order_sel, sleep;
  logic [7:0]  bsel_n;
  logic [63:0] wdata;
  logic [63:0] rdata;
  logic        dout_valid;

  int tests = 0;
  int fails = 0;
  logic [63:0] ref_mem [64];

  always #10 clk = ~clk;

  burst_sram dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ads_proc_n(ads_proc_n),
    .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
    .order_sel(order_sel), .sleep(sleep), .wdata(wdata), .rdata(rdata),
    .dout_valid(dout_valid)
  );

  function automatic logic [63:0] pat(int a, int salt);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = 8'(a * 7 + i * 29 + salt);
    return r;
  endfunction

  // Beat k of a group: linear adds modulo four, XOR order flips low bits.
  function automatic int beat_addr(int s, int k, bit xo);
    int lo = s % 4;
    int lk = xo ? (lo ^ k) : ((lo + k) % 4);
    return (s - lo) + lk;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ads_proc_n = 1; ads_ctrl_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bwe_n = 1; bsel_n = '1; oe_n = 0; sleep = 0; wdata = '0; addr = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic deselect();
    idle_inputs();
    ads_ctrl_n = 0; ce2 = 0;
    cyc();
    idle_inputs();
  endtask

  task automatic wr_burst(int s, int salt);
    for (int b = 0; b < 4; b++) begin
      int a = beat_addr(s, b, order_sel);
      idle_inputs();
      if (b == 0) begin ads_ctrl_n = 0; addr = 6'(s); end
      else adv_n = 0;
      gw_n = 0; wdata = pat(a, salt);
      cyc();
      ref_mem[a] = pat(a, salt);
    end
    deselect();
  endtask

  task automatic rd_burst(int s, bit use_proc, string req);
    for (int b = 0; b < 5; b++) begin
      idle_inputs();
      if (b == 0) begin
        if (use_proc) ads_proc_n = 0; else ads_ctrl_n = 0;
        addr = 6'(s);
      end else if (b < 4) adv_n = 0;
      else begin ads_ctrl_n = 0; ce2 = 0; end
      cyc();
      if (b == 0) chk("R9 first clock masked", {63'd0, dout_valid}, 64'd0);
      else begin
        chk(req, rdata, ref_mem[beat_addr(s, b - 1, order_sel)]);
        chk("R8 valid after one clock", {63'd0, dout_valid}, 64'd1);
      end
    end
    idle_inputs();
  endtask

  task automatic rd_single(int a, string req);
    idle_inputs(); ads_proc_n = 0; addr = 6'(a);
    cyc();
    deselect();
    chk(req, rdata, ref_mem[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    order_sel = 0;
    rst_n = 0;
    cyc(); cyc();
    chk("R9 reset output idle", {63'd0, dout_valid}, 64'd0);
    rst_n = 1;
    deselect();

    // R6 fill by global-write bursts, R5 linear order, R4 wrap
    for (int g = 0; g < 16; g++) wr_burst(g * 4 + (g % 4), 3);
    for (int s = 0; s < 64; s += 5) rd_burst(s, 1, "R5 linear order read");

    // R5 XOR order over every start offset
    order_sel = 1;
    deselect();
    for (int s = 0; s < 16; s++) wr_burst(s * 4 + (s % 4), 91);
    for (int s = 0; s < 64; s += 3) rd_burst(s, s % 2 == 0, "R5 xor order read");
    order_sel = 0;
    deselect();

    // R7 byte writes through the controller strobe
    for (int a = 0; a < 16; a++) begin
      logic [7:0] sel = 8'(a * 37 + 5);
      logic [63:0] d = ~pat(a, 11);
      idle_inputs(); ads_ctrl_n = 0; addr = 6'(a); bwe_n = 0; bsel_n = sel; wdata = d;
      cyc();
      for (int i = 0; i < 8; i++) if (!sel[i]) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
      deselect();
      rd_single(a, "R7 byte lane merge");
    end
    // R7 selects ignored without bwe_n; R6 gw_n overrides bwe_n high
    idle_inputs(); ads_ctrl_n = 0; addr = 6'd20; bsel_n = '0; wdata = '1; cyc(); deselect();
    rd_single(20, "R7 no write without byte enable");
    idle_inputs(); ads_ctrl_n = 0; addr = 6'd21; gw_n = 0; wdata = 64'h0123456789abcdef; cyc();
    ref_mem[21] = 64'h0123456789abcdef; deselect();
    rd_single(21, "R6 global write overrides");

    // R2 both strobes low: processor start reads, write ignored
    idle_inputs(); ads_proc_n = 0; ads_ctrl_n = 0; addr = 6'd30; gw_n = 0; wdata = '0; cyc();
    deselect();
    chk("R2 processor strobe read data", rdata, ref_mem[30]);
    chk("R2 processor strobe read valid", {63'd0, dout_valid}, 64'd1);
    rd_single(30, "R2 write ignored on processor start");

    // R3 processor strobe ignored while deselected and ce1_n high
    idle_inputs(); ads_proc_n = 0; ce1_n = 1; addr = 6'd31; cyc();
    idle_inputs(); cyc();
    chk("R3 ignored strobe gives no read", {63'd0, dout_valid}, 64'd0);
    deselect();
    // R3 mid-burst processor strobe with ce1_n high acts as advance
    idle_inputs(); ads_ctrl_n = 0; addr = 6'd40; cyc();
    idle_inputs(); ads_proc_n = 0; ce1_n = 1; adv_n = 0; addr = 6'd0; cyc();
    deselect();
    chk("R3 strobe treated as advance", rdata, ref_mem[41]);
    // R1/R3 controller strobe with ce1_n high deselects, no write
    idle_inputs(); ads_ctrl_n = 0; ce1_n = 1; addr = 6'd42; gw_n = 0; wdata = '0; cyc();
    idle_inputs(); adv_n = 0; gw_n = 0; wdata = '0; cyc();
    idle_inputs(); cyc();
    chk("R1 deselected burst gives no read", {63'd0, dout_valid}, 64'd0);
    rd_single(42, "R1 no write while deselected");
    rd_single(43, "R1 no burst write while deselected");

    // R4 advance high repeats the word
    idle_inputs(); ads_ctrl_n = 0; addr = 6'd50; cyc();
    idle_inputs(); cyc();
    chk("R4 start word", rdata, ref_mem[50]);
    idle_inputs(); adv_n = 0; cyc();
    chk("R4 hold repeats word", rdata, ref_mem[50]);
    deselect();
    chk("R4 step after hold", rdata, ref_mem[51]);

    // R9 output enable high blocks output
    idle_inputs(); ads_proc_n = 0; addr = 6'd5; cyc();
    idle_inputs(); oe_n = 1; adv_n = 0; cyc();
    chk("R9 oe_n high no output", {63'd0, dout_valid}, 64'd0);
    oe_n = 0; #1;
    chk("R9 oe_n low output", {63'd0, dout_valid}, 64'd1);
    deselect();

    // R10 sleep: no write, contents kept, leaves deselected
    idle_inputs(); ads_ctrl_n = 0; addr = 6'd60; cyc();
    idle_inputs(); sleep = 1; ads_ctrl_n = 0; addr = 6'd60; gw_n = 0; wdata = '0; cyc();
    idle_inputs(); sleep = 1; adv_n = 0; gw_n = 0; wdata = '0; cyc();
    idle_inputs(); adv_n = 0; cyc();
    idle_inputs(); cyc();
    chk("R10 no access after sleep", {63'd0, dout_valid}, 64'd0);
    deselect();
    rd_single(60, "R10 contents kept");
    rd_single(61, "R10 contents kept next");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule